// File: doc/BRIEF.md
# Serial Memory Bus Target Front End

This block is the bus-facing half of a two-wire serial memory. It watches the clock and data lines of an I2C bus, oversampled by a much faster system clock, and turns bus traffic into byte-level events for a memory core. It recognises Start and Stop conditions, assembles incoming bytes, compares the first byte of each transaction against a configured seven-bit device address, and acknowledges what it accepts by pulling the data line low through an open-drain enable. On reads it asks the core for a byte, shifts it out most significant bit first and watches the controller's acknowledge to decide whether to fetch another.

A busy input from the core marks an internal programming cycle. While it is high the block acknowledges nothing, not even its own address. A controller can therefore poll the device with its control byte and keep trying until an acknowledge comes back. Both lines pass through two-flop synchronizers, so the system clock must run at least eight times the bus clock rate.

Top module: `i2c_target_fe`

## Requirements
- R1: A falling data edge while the clock is high (Start) aborts any transfer in progress, clears the bit count and begins reception of a control byte, also when it arrives in the middle of a byte.
- R2: A rising data edge while the clock is high (Stop) returns the block to idle with the data line released; clock pulses after a Stop are ignored (no acknowledge, no strobe) until the next Start.
- R3: The block changes its data-line drive only while the clock line is low, apart from the release forced by a Start or Stop.
- R4: A control byte (seven address bits then a read/write bit, most significant bit first, 0 = write) whose address equals dev_addr while busy is low is acknowledged by holding the data line low across the whole ninth clock pulse; the line is released after that pulse.
- R5: A control byte with a different address is not acknowledged, and the block ignores every following byte (no acknowledge, no wr_stb) until the next Start or Stop.
- R6: While busy is high the block acknowledges no byte, including a control byte carrying its own address, and raises no wr_stb.
- R7: In a write transaction every data byte received while busy is low is acknowledged and wr_stb pulses for exactly one system clock with the byte on wr_data, as many bytes as the controller sends.
- R8: In a read transaction rd_req pulses for one system clock before each byte is sent; rd_data is taken in the clock cycle that follows the pulse and shifted out most significant bit first, the block pulling the line low for each 0 bit.
- R9: During the ninth clock of a read byte the block releases the line; a low level from the controller causes another rd_req and byte, a high level (NACK) leaves the line released with no further rd_req.
- R10: A repeated Start (a Start with no Stop before it) is accepted and the control byte that follows is handled as after a Start from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least eight times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| dev_addr | input | 7 | Configured device address |
| busy | input | 1 | Internal programming cycle in progress |
| wr_data | output | 8 | Last acknowledged write byte |
| wr_stb | output | 1 | One-cycle pulse for each acknowledged write byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte from the core, valid in the cycle after rd_req |

## Verification
Every reaction of the block follows a bus edge by two synchronizer cycles plus one register, so the data-line drive settles three to four system clocks after the clock line falls. The bench holds each bus clock phase for eight system clocks, changes data four cycles into the low phase and reads the data line six cycles into the high phase, well after the drive has settled and well before it may change again. The one-cycle strobes are captured at every rising clock edge into logs that the bench compares once each transaction ends, and the rule that drive changes only with the clock low is watched over the whole run.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_RD_LOAD,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic scl_hi;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] ctrl,
                                      input logic [ADDR_W-1:0] dev);
        return ctrl[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= 1'b1;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output line_evt_t evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.scl_hi   = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    tgt_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              is_ctrl;
    logic              rnw;
    logic              mack;
    logic              ack_ok;

    assign ack_ok = !busy && (!is_ctrl || addr_hit(shreg, dev_addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            is_ctrl <= 1'b0;
            rnw     <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
            rd_req  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_req <= 1'b0;
            if (evt.start) begin
                state   <= ST_RX;
                is_ctrl <= 1'b1;
                cnt     <= '0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (evt.scl_rise && cnt != FULL_CNT) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == FULL_CNT) begin
                            if (ack_ok) begin
                                sda_oe <= 1'b1;
                                state  <= ST_RX_ACK;
                                if (is_ctrl) begin
                                    rnw <= shreg[0];
                                end else begin
                                    wr_stb  <= 1'b1;
                                    wr_data <= shreg;
                                end
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe  <= 1'b0;
                            cnt     <= '0;
                            is_ctrl <= 1'b0;
                            if (is_ctrl && rnw) begin
                                rd_req <= 1'b1;
                                state  <= ST_RD_LOAD;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_RD_LOAD: begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_TX;
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (cnt == LAST_TX) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                rd_req <= 1'b1;
                                state  <= ST_RD_LOAD;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a Start always lands in control-byte reception with a cleared count
    a_r1_start_enters_ctrl: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_RX && is_ctrl && cnt == '0 && !sda_oe));

    // R2: a Stop returns to idle with the line released
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !evt.start) |=> (state == ST_IDLE && !sda_oe));

    // R3: drive changes only while the synchronized clock is low
    a_r3_drive_when_low: assert property (@(posedge clk) disable iff (rst)
        ((sda_oe != $past(sda_oe)) && !$past(evt.start) && !$past(evt.stop))
        |-> !$past(evt.scl_hi));

    // R6: an acknowledge is never raised for a byte while busy
    a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && $past(state) == ST_RX) |-> !$past(busy));

    // R7: write strobe lasts one cycle
    a_r7_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8: a read request is followed by shifting, not a second request
    a_r8_rd_then_tx: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !evt.start && !evt.stop) |=> (state == ST_TX && !rd_req));

    // R9: after a NACK or a mismatch the line stays released
    a_r9_ignore_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/i2c_target_fe.sv
module i2c_target_fe
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              busy,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              rd_req,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] synced;
    line_evt_t          evt;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar l = 0; l < N_LINES; l++) begin : g_line
            i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (raw[l]),
                .q   (synced[l])
            );
        end
    endgenerate

    i2c_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (synced[1]),
        .sda_s (synced[0]),
        .evt   (evt)
    );

    i2c_tgt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .dev_addr (dev_addr),
        .busy     (busy),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_req   (rd_req)
    );
endmodule

// File: tb/i2c_target_fe_test.sv
module i2c_target_fe_test;
    localparam logic [6:0] DEV = 7'h52;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       sda_oe, wr_stb, rd_req;
    logic [7:0] wr_data, rd_data;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    int rd_idx = 0;
    int wr_cnt = 0;
    logic [7:0] rd_bytes [0:63];
    logic [7:0] wr_log [0:255];
    logic       prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = rd_bytes[rd_idx[5:0]];

    i2c_target_fe uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .dev_addr(DEV), .busy(busy), .wr_data(wr_data), .wr_stb(wr_stb),
        .rd_req(rd_req), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (rd_req) rd_idx <= rd_idx + 1;
            if (wr_stb) begin
                wr_log[wr_cnt[7:0]] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (sda_oe !== prev_oe && scl_m) viol <= viol + 1;   // R3 monitor
        end
        prev_oe <= sda_oe;
    end

    function automatic bit exp_ctrl_ack(input logic [6:0] a, input bit b);
        return (a == DEV) && !b;
    endfunction

    function automatic string ctrl_req(input logic [6:0] a, input bit b);
        if (a != DEV) return "R5";
        if (b) return "R6";
        return "R4";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; w(4);
        scl_m = 1'b1; w(4);
        sda_m = 1'b0; w(4);
        scl_m = 1'b0; w(4);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; w(4);
        scl_m = 1'b1; w(4);
        sda_m = 1'b1; w(8);
    endtask

    task automatic send_bit(input bit b);
        w(4); sda_m = b; w(4);
        scl_m = 1'b1; w(8);
        scl_m = 1'b0;
    endtask

    task automatic read_bit(output bit b);
        w(4); sda_m = 1'b1; w(4);
        scl_m = 1'b1; w(6);
        b = sda_bus; w(2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        bit line;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        read_bit(line);
        acked = !line;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit line;
        for (int i = 7; i >= 0; i--) begin
            read_bit(line);
            d[i] = line;
        end
        send_bit(!give_ack);
    endtask

    task automatic chk_released(input string req);
        w(6);
        chk(req, sda_oe, 0);
    endtask

    task automatic do_txn(input logic [6:0] a, input bit rnw, input bit bsy, input int n);
        bit ack, exp;
        logic [7:0] d;
        int base;
        logic [7:0] sent [0:3];
        busy = bsy;
        exp = exp_ctrl_ack(a, bsy);
        bus_start();
        send_byte({a, rnw}, ack);
        chk(ctrl_req(a, bsy), ack, exp);
        if (!rnw) begin
            base = wr_cnt;
            for (int k = 0; k < n; k++) begin
                sent[k] = 8'($urandom);
                send_byte(sent[k], ack);
                chk(exp ? "R7" : ctrl_req(a, bsy), ack, exp);
            end
            chk_released("R4");
            chk(exp ? "R7" : ctrl_req(a, bsy), wr_cnt - base, exp ? n : 0);
            if (exp)
                for (int k = 0; k < n; k++) chk("R7", wr_log[base + k], sent[k]);
        end else if (exp) begin
            base = rd_idx;
            for (int k = 0; k < n; k++) begin
                recv_byte(d, k != n - 1);
                chk("R8", d, rd_bytes[(base + k) % 64]);
            end
            chk_released("R9");
            chk("R9", rd_idx - base, n);
        end
        bus_stop();
        busy = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        int base;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) rd_bytes[i] = 8'($urandom);
        w(5);
        rst = 1'b0;
        w(3);
        // reset state
        chk("R2", {sda_oe, wr_stb, rd_req}, 3'b000);

        // directed: plain write, mismatch, busy poll, read
        do_txn(DEV, 1'b0, 1'b0, 3);
        do_txn(DEV ^ 7'h01, 1'b0, 1'b0, 2);
        do_txn(DEV, 1'b0, 1'b1, 1);
        do_txn(DEV, 1'b1, 1'b1, 1);
        do_txn(DEV, 1'b1, 1'b0, 3);
        do_txn(DEV, 1'b1, 1'b0, 1);

        // R2: clocking after a Stop is ignored
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk("R4", ack, 1);
        bus_stop();
        base = wr_cnt;
        sda_m = 1'b1; scl_m = 1'b0;
        send_byte(8'hA5, ack);
        chk("R2", ack, 0);
        chk("R2", wr_cnt - base, 0);
        scl_m = 1'b1; w(8);

        // R1: Start in the middle of a byte restarts control reception
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk("R1", ack, 1);
        base = wr_cnt;
        send_byte(8'h3C, ack);
        chk("R1", ack, 1);
        chk("R1", wr_log[base], 8'h3C);
        bus_stop();

        // R10: repeated Start from write into read
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h07, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        chk("R10", ack, 1);
        base = rd_idx;
        recv_byte(d, 1'b0);
        chk("R10", d, rd_bytes[base % 64]);
        bus_stop();

        // randomized mix
        for (int t = 0; t < 24; t++) begin
            logic [6:0] a;
            a = ($urandom % 10 < 7) ? DEV : 7'($urandom);
            do_txn(a, 1'($urandom), ($urandom % 4) == 0, 1 + ($urandom % 3));
        end

        chk("R3", viol, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule